// File: doc/BRIEF.md
# Handshaked FIFO with occupancy flags

This block is a first-in/first-out buffer, 64 words deep and 5 bits wide by default. Each side uses a strobe-and-ready handshake. A producer drives a word together with a shift-in strobe while the input-ready line is high. A consumer reads the oldest word whenever the output-ready line is high and pulses a shift-out strobe to move on to the next word. The model is synchronous on a single clock. A strobe that is high on a rising edge counts as one shift event.

Two flags report the fill level. The half flag is high at or above half capacity. The edge flag is high near either end of the range: when the buffer is almost full or almost empty. An asynchronous master reset empties the buffer. An output-enable input floats the data outputs and leaves every other output alone.

A four-state controller sets both ready lines. Its states are HOLD (in reset, or in the first edge after reset), EMPTY, PART (partly filled) and FULL. Its transitions are:
- release: HOLD to EMPTY.
- first_load: EMPTY to PART.
- top_off: PART to FULL, when the count reaches capacity.
- drain: PART to EMPTY, when the count reaches zero.
- make_room: FULL to PART.
- Any state returns to HOLD on reset.

Top module: `hs_fifo`

## Requirements
- R1: Words leave in the order they were accepted, and up to 64 words can be held at once.
- R2: `half_flag` is 1 exactly when 32 or more words are stored. It updates in the cycle after the accepting strobe.
- R3: `edge_flag` is 1 when 56 or more words are stored, and also when 8 or fewer are stored. It is 0 in between and updates in the cycle after the strobe.
- R4: `in_rdy` is 1 only when fewer than 64 words are stored. Accepting the 64th word drops it on the next edge. Removing a word from a full buffer raises it on the next edge.
- R5: A shift-in strobe while `in_rdy` is 0 is ignored. The count, the flags and the stored words do not change.
- R6: A word accepted into an empty buffer appears on `dout` with `out_rdy` = 1 on the next edge. An accepted shift-out presents the next word on the next edge, or drops `out_rdy` if that was the last word.
- R7: A shift-out strobe while `out_rdy` is 0 is ignored. `dout` stays 0 and the count does not change.
- R8: When shift-in and shift-out are both accepted on the same edge, both take effect. The count is unchanged, and the outgoing word is replaced by the next older word.
- R9: While `rst` is 1, the buffer is empty, `dout` is 0, `out_rdy` = 0, `in_rdy` = 0, `half_flag` = 0 and `edge_flag` = 1. `in_rdy` rises on the first clock edge after `rst` falls.
- R10: With `oe` = 0, `dout` is high-impedance. `in_rdy`, `out_rdy` and both flags are unaffected by `oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, asynchronous, active high |
| in_stb | input | 1 | Shift-in strobe |
| din | input | 5 | Word to load |
| in_rdy | output | 1 | Buffer can accept a word |
| out_stb | input | 1 | Shift-out strobe |
| out_rdy | output | 1 | Valid word on `dout` |
| oe | input | 1 | Output enable for `dout` |
| dout | output | 5 | Oldest word, 0 when empty, Z when disabled |
| half_flag | output | 1 | 32 or more words stored |
| edge_flag | output | 1 | 56 or more, or 8 or fewer, words stored |

## Verification
The hardest situations to reach from the ports are full with a simultaneous strobe on both sides, and the edges where the flag thresholds are crossed in each direction. The stimulus fills the buffer one word per cycle from empty to full. At full it issues both strobes at once, so only the removal is honoured and `in_rdy` pulses back. It then drains to empty. Every intermediate count is compared against the arithmetic model, so each threshold is passed rising and falling. A phase of paired strobes at a mid level and a reset issued while data is held finish the sweep.

// File: rtl/hs_fifo_pkg.sv
package hs_fifo_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_EMPTY = 2'd1,
        ST_PART  = 2'd2,
        ST_FULL  = 2'd3
    } fifo_state_e;
endpackage

// File: rtl/hs_fifo_ctrl.sv
module hs_fifo_ctrl
    import hs_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_stb,
    input  logic          out_stb,
    output logic          in_rdy,
    output logic          out_rdy,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    fifo_state_e state_q, state_d;
    logic        rd_en;
    logic [CW-1:0] count_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        in_rdy  = 1'b0;
        out_rdy = 1'b0;
        unique case (state_q)
            ST_HOLD:  begin in_rdy = 1'b0; out_rdy = 1'b0; end
            ST_EMPTY: begin in_rdy = 1'b1; out_rdy = 1'b0; end
            ST_PART:  begin in_rdy = 1'b1; out_rdy = 1'b1; end
            ST_FULL:  begin in_rdy = 1'b0; out_rdy = 1'b1; end
        endcase
    end

    assign wr_en = in_stb && in_rdy;
    assign rd_en = out_stb && out_rdy;

    always_comb begin
        count_d = count;
        if (wr_en && !rd_en) count_d = count + 1'b1;
        if (rd_en && !wr_en) count_d = count - 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_EMPTY;
            ST_EMPTY: if (wr_en) state_d = ST_PART;
            ST_PART: begin
                if (count_d == '0)           state_d = ST_EMPTY;
                else if (count_d == FULL_CNT) state_d = ST_FULL;
            end
            ST_FULL:  if (rd_en) state_d = ST_PART;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            count <= count_d;
            if (wr_en) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    a_r5_ignore_in: assert property (@(posedge clk) disable iff (rst)
        (in_stb && !in_rdy && !out_stb) |=> $stable(count));
    a_r7_ignore_out: assert property (@(posedge clk) disable iff (rst)
        (out_stb && !out_rdy && !in_stb) |=> $stable(count));
    a_r8_both_sides: assert property (@(posedge clk) disable iff (rst)
        (in_stb && in_rdy && out_stb && out_rdy) |=> $stable(count));
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_CNT) |-> !in_rdy);
    a_r6_nonempty_ready: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> out_rdy);
endmodule

// File: rtl/hs_fifo_store.sv
module hs_fifo_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 5,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/hs_fifo_flags.sv
module hs_fifo_flags #(
    parameter int DEPTH    = 64,
    parameter int HALF_LVL = 32,
    parameter int HIGH_LVL = 56,
    parameter int LOW_LVL  = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    output logic          half_flag,
    output logic          edge_flag
);
    localparam logic [CW-1:0] HALF_C = CW'(HALF_LVL);
    localparam logic [CW-1:0] HIGH_C = CW'(HIGH_LVL);
    localparam logic [CW-1:0] LOW_C  = CW'(LOW_LVL);

    assign half_flag = (count >= HALF_C);
    assign edge_flag = (count >= HIGH_C) || (count <= LOW_C);
endmodule

// File: rtl/hs_fifo.sv
module hs_fifo #(
    parameter int DEPTH    = 64,
    parameter int WIDTH    = 5,
    parameter int HALF_LVL = 32,
    parameter int HIGH_LVL = 56,
    parameter int LOW_LVL  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_stb,
    input  logic [WIDTH-1:0] din,
    output logic             in_rdy,
    input  logic             out_stb,
    output logic             out_rdy,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             half_flag,
    output logic             edge_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [WIDTH-1:0] rd_data, q_int;

    hs_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb),
        .in_rdy(in_rdy), .out_rdy(out_rdy), .wr_en(wr_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
    );

    hs_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(din),
        .rd_ptr(rd_ptr), .rd_data(rd_data)
    );

    hs_fifo_flags #(.DEPTH(DEPTH), .HALF_LVL(HALF_LVL),
                    .HIGH_LVL(HIGH_LVL), .LOW_LVL(LOW_LVL)) flags_i (
        .count(count), .half_flag(half_flag), .edge_flag(edge_flag)
    );

    assign q_int = out_rdy ? rd_data : '0;
    assign dout  = oe ? q_int : {WIDTH{1'bz}};

    a_r2_half_needs_data: assert property (@(posedge clk) disable iff (rst)
        !out_rdy |-> !half_flag);
    a_r3_edge_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_rdy |-> edge_flag);
    a_r9_reset_state: assert property (@(posedge clk)
        rst |-> (!in_rdy && !out_rdy && !half_flag && edge_flag));
endmodule

// File: tb/hs_fifo_tb_top.sv
module hs_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_stb = 1'b0, out_stb = 1'b0, oe = 1'b1;
    logic [4:0] din = '0;
    wire  [4:0] dout;
    wire  in_rdy, out_rdy, half_flag, edge_flag;

    int vectors = 0;
    int errors  = 0;
    int model_q[$];
    bit live = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_fifo dut_i (
        .clk(clk), .rst(rst), .in_stb(in_stb), .din(din), .in_rdy(in_rdy),
        .out_stb(out_stb), .out_rdy(out_rdy), .oe(oe), .dout(dout),
        .half_flag(half_flag), .edge_flag(edge_flag)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int n = model_q.size();
        check("R4 in_rdy", {31'b0, in_rdy}, {31'b0, live && n < DEPTH});
        check("R6 out_rdy", {31'b0, out_rdy}, {31'b0, n > 0});
        check("R2 half_flag", {31'b0, half_flag}, {31'b0, n >= 32});
        check("R3 edge_flag", {31'b0, edge_flag}, {31'b0, (n >= 56) || (n <= 8)});
        if (oe) check("R1 dout order", {27'b0, dout}, (n > 0) ? model_q[0] : 0);
        else    check("R10 dout hi-z", {27'b0, dout}, {27'b0, 5'bzzzzz});
    endtask

    // one clock with the given strobes; model updated from current readiness
    task automatic step(bit si, bit so, logic [4:0] d);
        bit acc_in, acc_out;
        in_stb = si; out_stb = so; din = d;
        acc_in  = si && live && model_q.size() < DEPTH;
        acc_out = so && model_q.size() > 0;
        @(posedge clk);
        #1;
        if (acc_out) void'(model_q.pop_front());
        if (acc_in) model_q.push_back(int'(d));
        live = !rst;
        in_stb = 0; out_stb = 0;
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        #2;
        check_all();
        check("R9 out_rdy in reset", {31'b0, out_rdy}, 0);
        check("R9 edge in reset", {31'b0, edge_flag}, 1);
        step(1, 0, 5'h11);   // ignored under reset
        check("R9 in_rdy held low", {31'b0, in_rdy}, 0);
        rst = 1'b0;
        #1;
        check("R9 in_rdy still low before edge", {31'b0, in_rdy}, 0);
        step(0, 0, 0);
        check("R9 in_rdy after release", {31'b0, in_rdy}, 1);

        // R7: shift-out on empty ignored
        step(0, 1, 0);
        check("R7 dout zero when empty", {27'b0, dout}, 0);

        // R6: word into empty visible next edge
        step(1, 0, 5'h15);
        check("R6 fall-through", {27'b0, dout}, 32'h15);
        step(0, 1, 0);

        // R1/R2/R3/R4: fill to full, every level checked
        for (int i = 0; i < DEPTH; i++) step(1, 0, 5'((i * 7 + 3) % 32));
        check("R4 full drops in_rdy", {31'b0, in_rdy}, 0);
        // R5: shift-in at full ignored
        step(1, 0, 5'h1F);
        check("R5 count unchanged", {31'b0, edge_flag}, 1);
        // R4/R8: both strobes at full, only removal honoured
        step(1, 1, 5'h1E);
        check("R4 in_rdy pulses back", {31'b0, in_rdy}, 1);
        step(1, 0, 5'h0A);
        // drain completely, checking order and thresholds downward
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0);
        check("R6 drained", {31'b0, out_rdy}, 0);

        // R8: simultaneous strobes at mid level
        for (int i = 0; i < 20; i++) step(1, 0, 5'(i + 9));
        for (int i = 0; i < 30; i++) step(1, 1, 5'(i * 3));
        check("R8 level held", {31'b0, half_flag}, 0);

        // R10: output enable
        oe = 1'b0;
        #1;
        check_all();
        step(1, 1, 5'h07);
        oe = 1'b1;
        #1;
        check_all();

        // R9: reset with data held
        rst = 1'b1;
        #1;
        model_q.delete();
        live = 1'b0;
        check_all();
        check("R9 dout low in reset", {27'b0, dout}, 0);
        step(0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0);
        step(1, 0, 5'h03);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule